// File: doc/BRIEF.md
# Banked Prioritized Interrupt Controller

This block collects up to 32 interrupt request lines, holds the ones that arrive as edges, masks them per line, and picks one winner for each of two processor outputs: a normal interrupt and a fast interrupt. Each line carries its own configuration word with a fast-interrupt route bit, an edge/level selector and a priority. Once an output asserts, the winning line index is frozen and can be read back. It stays frozen until software writes the acknowledge bit for that output.

Lines in a larger system are numbered n. Line n belongs to instance n>>5 at bit n&31. A parameter makes the instance either a first level or a second level. A first level can route lines to the fast output and has a global gate on both outputs. A second level only drives the normal output, and that output is wired into one line of a first-level instance. Servicing a second-level source therefore needs an acknowledge at both levels.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset both outputs are low, the mask register (offset 0x04) reads all ones, the status register (offset 0x00) reads 0, and in a first-level instance the global gate (offset 0x14) reads 1.
- R2: A mask bit of 1 keeps its line from arbitration. A mask bit of 0 lets the line compete.
- R3: The configuration word of line n sits at offset 0x80+4*n. Bit 0 routes the line to the fast output, bit 1 selects edge (1) or level (0) sensitivity, bits 6:2 hold the priority. The word reads back as written.
- R4: In a second-level instance the route bit reads 0, the line goes to the normal output, and the fast output never asserts.
- R5: Among unmasked pending lines, the lowest priority value wins and ties go to the lowest line index. The output asserts on the clock edge after the line becomes pending. The winner index reads at offset 0x08 (normal) or 0x0C (fast), bits 4:0.
- R6: While an output is asserted, its winner index does not change, even when a more urgent line arrives.
- R7: A write to offset 0x10 with bit 0 set releases the normal output, and bit 1 releases the fast output. The released output is low in the cycle after the write and reasserts later if an unmasked line is still pending.
- R8: An edge line latches a rising input and keeps it pending until the line is acknowledged as a winner. A level line's pending state follows its input.
- R9: The status register shows every line's pending state regardless of mask. Writing 0 to it clears all latched edges, and a nonzero write has no effect.
- R10: In a first-level instance a global gate value of 1 keeps both outputs low and blocks arbitration, and writing 0 enables delivery. In a second-level instance the gate reads 0 and has no effect.
- R11: When a second-level normal output drives a first-level line, the first level reports that line. The first level reasserts after its own acknowledge for as long as the second level still requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NLINES | Interrupt request lines |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | IDX_W+3 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Normal interrupt to the processor |
| fiq_out | output | 1 | Fast interrupt to the processor |

## Verification
On every cycle the assertions check four things: winner indices stay frozen while an output is held, an output drops right after its acknowledge, a free output captures an eligible candidate on the next edge, and latched edges are lost only through an acknowledge or a status clear. The bench's scenarios are needed for the rest. These include the priority and tie-break order across many request and mask patterns, configuration readback, and the global gate. They also cover fast-interrupt routing and its suppression in a second level, and the two-level cascade with its double acknowledge.

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl #(
  parameter int NLINES = 32,
  parameter int PRIO_W = 5,
  parameter bit FIRST_LEVEL = 1'b1,
  localparam int IDX_W = $clog2(NLINES),
  localparam int AW = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out,
  output logic              fiq_out
);
  localparam logic [AW-1:0] A_STAT = AW'('h00);
  localparam logic [AW-1:0] A_MASK = AW'('h04);
  localparam logic [AW-1:0] A_IWIN = AW'('h08);
  localparam logic [AW-1:0] A_FWIN = AW'('h0C);
  localparam logic [AW-1:0] A_CTRL = AW'('h10);
  localparam logic [AW-1:0] A_GATE = AW'('h14);
  localparam logic [NLINES-1:0] ONE = NLINES'(1);

  logic [NLINES-1:0] mask_q, in_q, edge_pend_q, cfg_fast, cfg_edge;
  logic [PRIO_W-1:0] cfg_prio [NLINES];
  logic              gate_q;
  logic              irq_busy, fiq_busy, irq_gap, fiq_gap;
  logic [IDX_W-1:0]  irq_win, fiq_win;

  logic [NLINES-1:0] pending, cand, icand, fcand, ack_clr;
  logic              i_any, f_any;
  logic [IDX_W-1:0]  i_idx, f_idx;
  logic [PRIO_W-1:0] i_best, f_best;

  wire              cfg_sel  = bus_addr[AW-1];
  wire [IDX_W-1:0]  cfg_idx  = bus_addr[IDX_W+1:2];
  wire              wr_cfg   = bus_wr && cfg_sel;
  wire              stat_clr = bus_wr && bus_addr == A_STAT && bus_wdata == 32'd0;
  wire              ack_irq  = bus_wr && bus_addr == A_CTRL && bus_wdata[0];
  wire              ack_fiq  = bus_wr && bus_addr == A_CTRL && bus_wdata[1];
  wire              gate_eff = FIRST_LEVEL ? gate_q : 1'b0;

  assign pending = (cfg_edge & edge_pend_q) | (~cfg_edge & irq_in);
  assign cand    = pending & ~mask_q;
  assign icand   = cand & ~cfg_fast;
  assign fcand   = cand & cfg_fast;
  assign ack_clr = ((ack_irq && irq_busy) ? (ONE << irq_win) : '0)
                 | ((ack_fiq && fiq_busy) ? (ONE << fiq_win) : '0);

  always_comb begin
    i_any = 1'b0; i_idx = '0; i_best = '1;
    f_any = 1'b0; f_idx = '0; f_best = '1;
    for (int n = 0; n < NLINES; n++) begin
      if (icand[n] && (!i_any || cfg_prio[n] < i_best)) begin
        i_any = 1'b1; i_idx = IDX_W'(n); i_best = cfg_prio[n];
      end
      if (fcand[n] && (!f_any || cfg_prio[n] < f_best)) begin
        f_any = 1'b1; f_idx = IDX_W'(n); f_best = cfg_prio[n];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q      <= '1;
      gate_q      <= 1'b1;
      in_q        <= '0;
      edge_pend_q <= '0;
      cfg_fast    <= '0;
      cfg_edge    <= '0;
      for (int n = 0; n < NLINES; n++) cfg_prio[n] <= '0;
    end else begin
      in_q <= irq_in;
      edge_pend_q <= stat_clr ? '0
                   : ((edge_pend_q & ~ack_clr) | (irq_in & ~in_q & cfg_edge));
      if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata[NLINES-1:0];
      if (bus_wr && bus_addr == A_GATE) gate_q <= bus_wdata[0];
      if (wr_cfg) begin
        cfg_fast[cfg_idx] <= FIRST_LEVEL & bus_wdata[0];
        cfg_edge[cfg_idx] <= bus_wdata[1];
        cfg_prio[cfg_idx] <= bus_wdata[PRIO_W+1:2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_busy <= 1'b0; irq_gap <= 1'b0; irq_win <= '0;
      fiq_busy <= 1'b0; fiq_gap <= 1'b0; fiq_win <= '0;
    end else begin
      if (ack_irq) begin
        irq_busy <= 1'b0; irq_gap <= 1'b1;
      end else if (irq_gap) begin
        irq_gap <= 1'b0;
      end else if (!irq_busy && i_any && !gate_eff) begin
        irq_busy <= 1'b1; irq_win <= i_idx;
      end
      if (ack_fiq) begin
        fiq_busy <= 1'b0; fiq_gap <= 1'b1;
      end else if (fiq_gap) begin
        fiq_gap <= 1'b0;
      end else if (!fiq_busy && f_any && !gate_eff) begin
        fiq_busy <= 1'b1; fiq_win <= f_idx;
      end
    end
  end

  assign irq_out = irq_busy & ~gate_eff;
  assign fiq_out = fiq_busy & ~gate_eff;

  always_comb begin
    bus_rdata = '0;
    if (cfg_sel) begin
      bus_rdata[PRIO_W+1:0] = {cfg_prio[cfg_idx], cfg_edge[cfg_idx], cfg_fast[cfg_idx]};
    end else begin
      case (bus_addr)
        A_STAT: bus_rdata[NLINES-1:0] = pending;
        A_MASK: bus_rdata[NLINES-1:0] = mask_q;
        A_IWIN: bus_rdata[IDX_W-1:0]  = irq_win;
        A_FWIN: bus_rdata[IDX_W-1:0]  = fiq_win;
        A_GATE: bus_rdata[0]          = gate_eff;
        default: bus_rdata = '0;
      endcase
    end
  end

  p_irq_win_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_busy && !ack_irq) |=> (irq_busy && $stable(irq_win)));
  p_fiq_win_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_busy && !ack_fiq) |=> (fiq_busy && $stable(fiq_win)));
  p_irq_gap_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_irq |=> !irq_out);
  p_fiq_gap_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fiq |=> !fiq_out);
  p_irq_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_busy && !irq_gap && !ack_irq && i_any && !gate_eff)
      |=> (irq_out && irq_win == $past(i_idx)));
  p_edge_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_clr && !ack_irq && !ack_fiq)
      |=> ((edge_pend_q & $past(edge_pend_q)) == $past(edge_pend_q)));
endmodule

// File: tb/test_irq_bank_ctrl.sv
module test_irq_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tb_in = '0, sec_in = '0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, rd_a, rd_b;
  logic        wr_a = 1'b0, wr_b = 1'b0;
  logic        irq_a, fiq_a, irq_b, fiq_b;
  int          nchk = 0, nfail = 0;
  logic [31:0] r;

  localparam logic [7:0] STAT = 8'h00, MASK = 8'h04, IWIN = 8'h08,
                         FWIN = 8'h0C, CTRL = 8'h10, GATE = 8'h14;

  // {in[31:0], mask[31:0], expected out, expected winner[4:0]}
  localparam logic [69:0] VEC [8] = '{
    {32'h0000_0001, 32'h0000_0000, 1'b1, 5'd0},
    {32'h0010_0100, 32'h0000_0000, 1'b1, 5'd20},
    {32'h0010_0002, 32'h0000_0000, 1'b1, 5'd1},
    {32'h0010_0002, 32'h0000_0002, 1'b1, 5'd20},
    {32'h8000_0000, 32'h0000_0000, 1'b1, 5'd31},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 5'd0},
    {32'hC000_0000, 32'h4000_0000, 1'b1, 5'd31},
    {32'h0000_00F0, 32'h0000_0000, 1'b1, 5'd4}
  };

  always #5 clk = ~clk;

  irq_bank_ctrl #(.FIRST_LEVEL(1'b1)) i_irq_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in({tb_in[31:1], tb_in[0] | irq_b}),
    .bus_wr(wr_a), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_a), .irq_out(irq_a), .fiq_out(fiq_a));

  irq_bank_ctrl #(.FIRST_LEVEL(1'b0)) i_sec (
    .clk(clk), .rst_n(rst_n), .irq_in(sec_in),
    .bus_wr(wr_b), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_b), .irq_out(irq_b), .fiq_out(fiq_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit sec, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d;
    if (sec) wr_b = 1'b1; else wr_a = 1'b1;
    @(negedge clk);
    wr_a = 1'b0; wr_b = 1'b0;
  endtask

  task automatic rd(input bit sec, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = sec ? rd_b : rd_a;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] prio_word(input int n);
    return (n == 20) ? 32'd0 : 32'(n >> 2) << 2;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    waitc(3);
    rst_n = 1'b1;
    waitc(1);
    // R1 reset state
    chk("R1 irq_out", 32'(irq_a), 0);
    chk("R1 fiq_out", 32'(fiq_a), 0);
    rd(0, MASK, r); chk("R1 mask", r, 32'hFFFF_FFFF);
    rd(0, STAT, r); chk("R1 status", r, 0);
    rd(0, GATE, r); chk("R1 gate", r, 1);
    rd(1, GATE, r); chk("R10 second-level gate", r, 0);

    for (int n = 0; n < 32; n++) wr(0, 8'(128 + 4 * n), prio_word(n));
    rd(0, 8'(128 + 4 * 20), r); chk("R3 readback line 20", r, 0);
    rd(0, 8'(128 + 4 * 9), r); chk("R3 readback line 9", r, 32'h8);
    wr(0, GATE, 0);

    // R2 R5 table walk
    for (int v = 0; v < 8; v++) begin
      wr(0, MASK, VEC[v][37:6]);
      tb_in = VEC[v][69:38];
      waitc(3);
      chk($sformatf("R2/R5 vec%0d out", v), 32'(irq_a), 32'(VEC[v][5]));
      if (VEC[v][5]) begin
        rd(0, IWIN, r);
        chk($sformatf("R5 vec%0d winner", v), r, 32'(VEC[v][4:0]));
      end
      tb_in = '0;
      wr(0, CTRL, 1);
      waitc(3);
      chk($sformatf("R7 vec%0d idle", v), 32'(irq_a), 0);
    end
    wr(0, MASK, 0);

    // R6 freeze, R7 gap and re-arbitration
    tb_in[10] = 1'b1;
    waitc(3);
    rd(0, IWIN, r); chk("R6 first winner", r, 10);
    tb_in[2] = 1'b1;
    waitc(3);
    rd(0, IWIN, r); chk("R6 frozen winner", r, 10);
    chk("R6 out held", 32'(irq_a), 1);
    wr(0, CTRL, 1);
    chk("R7 low after ack", 32'(irq_a), 0);
    waitc(3);
    chk("R7 reassert", 32'(irq_a), 1);
    rd(0, IWIN, r); chk("R7 new winner", r, 2);
    tb_in = '0;
    wr(0, CTRL, 1);
    waitc(3);

    // R3 fast routing
    wr(0, 8'(128 + 4 * 5), 32'h0D);
    rd(0, 8'(128 + 4 * 5), r); chk("R3 readback fast word", r, 32'h0D);
    tb_in[5] = 1'b1;
    waitc(3);
    chk("R3 fiq_out", 32'(fiq_a), 1);
    chk("R3 irq_out idle", 32'(irq_a), 0);
    rd(0, FWIN, r); chk("R5 fast winner", r, 5);
    wr(0, CTRL, 1);
    waitc(2);
    chk("R7 bit0 leaves fast held", 32'(fiq_a), 1);
    tb_in = '0;
    wr(0, CTRL, 2);
    chk("R7 fast low after ack", 32'(fiq_a), 0);
    waitc(3);
    chk("R7 fast stays low", 32'(fiq_a), 0);
    wr(0, 8'(128 + 4 * 5), prio_word(5));

    // R8 edge latch
    wr(0, 8'(128 + 4 * 12), 32'h06);
    @(negedge clk); tb_in[12] = 1'b1;
    @(negedge clk); tb_in[12] = 1'b0;
    waitc(3);
    chk("R8 edge captured", 32'(irq_a), 1);
    rd(0, IWIN, r); chk("R8 edge winner", r, 12);
    rd(0, STAT, r); chk("R8 edge still pending", r, 32'h1000);
    wr(0, CTRL, 1);
    waitc(3);
    chk("R8 edge cleared out", 32'(irq_a), 0);
    rd(0, STAT, r); chk("R8 edge cleared status", r, 0);
    wr(0, MASK, 32'h2000);
    tb_in[13] = 1'b1;
    rd(0, STAT, r); chk("R8 level follows high", r, 32'h2000);
    tb_in[13] = 1'b0;
    rd(0, STAT, r); chk("R8 level follows low", r, 0);

    // R9 status clear, R10 gate
    wr(0, GATE, 1);
    @(negedge clk); tb_in[12] = 1'b1;
    @(negedge clk); tb_in[12] = 1'b0;
    waitc(2);
    chk("R10 gated out", 32'(irq_a), 0);
    rd(0, STAT, r); chk("R9 latched", r, 32'h1000);
    wr(0, STAT, 5);
    rd(0, STAT, r); chk("R9 nonzero write ignored", r, 32'h1000);
    wr(0, STAT, 0);
    rd(0, STAT, r); chk("R9 cleared", r, 0);
    tb_in[3] = 1'b1;
    waitc(3);
    chk("R10 gate blocks", 32'(irq_a), 0);
    wr(0, GATE, 0);
    waitc(3);
    chk("R10 enabled", 32'(irq_a), 1);
    rd(0, IWIN, r); chk("R10 winner", r, 3);
    tb_in = '0;
    wr(0, CTRL, 1);
    waitc(3);

    // R4 second level, R11 cascade
    wr(1, 8'(128 + 4 * 7), 32'h7F);
    rd(1, 8'(128 + 4 * 7), r); chk("R4 route bit reads 0", r, 32'h7E);
    wr(1, MASK, ~32'h80);
    wr(0, MASK, 32'hFFFF_FFFE);
    sec_in[7] = 1'b1;
    waitc(4);
    chk("R4 second irq_out", 32'(irq_b), 1);
    chk("R4 second fiq_out", 32'(fiq_b), 0);
    chk("R11 first irq_out", 32'(irq_a), 1);
    rd(1, IWIN, r); chk("R11 second winner", r, 7);
    rd(0, IWIN, r); chk("R11 first winner", r, 0);
    wr(0, CTRL, 1);
    waitc(4);
    chk("R11 first reasserts", 32'(irq_a), 1);
    sec_in = '0;
    wr(1, CTRL, 1);
    wr(0, CTRL, 1);
    waitc(3);
    chk("R11 both idle first", 32'(irq_a), 0);
    chk("R11 both idle second", 32'(irq_b), 0);

    summary();
    $finish;
  end
endmodule